// File: doc/BRIEF.md
# Pending-Ack Miss Tracker

This block keeps a small table of misses that are still waiting on the coherence network. Each entry is keyed by line address. The line controller allocates an entry when it issues a read miss, a write miss, an upgrade or a writeback. At allocation the entry records the address, the transient state code, a snapshot of the line's data and its dirty bit, and a signed pending-ack count that starts at zero.

Every response that reaches the tracker carries an address, a kind, a sender class (peer cache or not) and a signed ack count. The tracker looks up the address and classifies the response into one event code for the line controller. It subtracts the message's ack count from the entry's pending count. An entry is freed on the event that completes it: data with nothing left, the last ack, shared data from a peer cache, or a writeback ack. Data and acks may arrive in either order, so the pending count can go below zero while acks lead data.

One cycle after each response, the tracker reports the event together with the entry's remaining count and the stored data snapshot. The requester must stall while `alloc_full` is high.

Top module: `pend_ack_tracker`

## Requirements
- R1: Allocation stores the address, the transient state, the data and the dirty bit, and sets the pending count to 0. Any later response whose address matches the entry reports that stored data on `evt_data` and that dirty bit on `evt_dirty`.
- R2: A data response (`resp_type` 0) gives event code 1 (data complete) and frees the entry when pending minus `resp_ack_cnt` equals 0. This rule applies unless R5 applies first.
- R3: A data response that completes nothing gives event code 0 (partial data). The entry stays, its pending count becomes pending minus `resp_ack_cnt`, and `evt_left` reports the new count.
- R4: An ack response (`resp_type` 1) gives event code 4 (last ack) and frees the entry when pending minus `resp_ack_cnt` is 0. Otherwise it gives code 3 (partial ack) and stores the difference. The count may go negative when acks lead data.
- R5: A data response with `resp_from_peer`=1 is classified as code 2 (shared data from a peer) and frees the entry, whatever the count, when the entry's state is a read-wait code. The read-wait codes are 0 through 3: read wait, read wait after invalidate, prefetch read wait, and prefetch read wait after invalidate. The other states are 4 (write wait), 5 (upgrade wait), 6 (writeback wait), 7 (prefetch write wait) and 8 (prefetch upgrade wait).
- R6: A writeback ack (`resp_type` 2) gives code 5 and frees the entry.
- R7: A response that matches no entry, or that has `resp_type` 3, gives code 6 (ignored). It leaves the table unchanged, and `evt_left` is 0.
- R8: `alloc_full` is high exactly when every entry is in use. An allocation while it is high creates no entry.
- R9: `evt_valid` is high in the cycle after a cycle with `resp_valid` high, and low otherwise. `evt_left` is 0 for every completing event.
- R10: After reset the table is empty, `alloc_full` is 0 and `evt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry this cycle |
| alloc_addr | input | ADDR_W | Line address of the new miss |
| alloc_state | input | 4 | Transient state code (see R5) |
| alloc_data | input | DATA_W | Snapshot of the line data |
| alloc_dirty | input | 1 | Snapshot of the dirty bit |
| alloc_full | output | 1 | All entries in use; the requester stalls |
| resp_valid | input | 1 | A response is presented |
| resp_addr | input | ADDR_W | Response line address |
| resp_type | input | 2 | 0 data, 1 ack, 2 writeback ack, 3 reserved |
| resp_from_peer | input | 1 | Sender is a peer cache |
| resp_ack_cnt | input | CNT_W | Signed ack count carried by the response |
| evt_valid | output | 1 | Event outputs valid |
| evt_code | output | 3 | Event classification (codes in R2 to R7) |
| evt_left | output | CNT_W | Signed pending count after the response |
| evt_data | output | DATA_W | Data snapshot of the matched entry |
| evt_dirty | output | 1 | Dirty snapshot of the matched entry |

## Verification
- `alloc_full` is combinational on the table. The bench checks it at the falling edge before it drives each allocation.
- An allocation takes effect at the next rising edge.
- A response sets the event outputs and updates the table at the rising edge after it is driven. The bench drives each response at a falling edge and compares `evt_code`, `evt_left` and the snapshot one falling edge later, one registered stage after the stimulus.
- Because the table changes at that same edge, the bench's expected table advances in step, so back-to-back responses to one address see the updated count.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;
   // response kinds
   localparam logic [1:0] RSP_DATA  = 2'd0;
   localparam logic [1:0] RSP_ACK   = 2'd1;
   localparam logic [1:0] RSP_WBACK = 2'd2;

   // event codes
   localparam logic [2:0] EV_DATA_PART   = 3'd0;
   localparam logic [2:0] EV_DATA_DONE   = 3'd1;
   localparam logic [2:0] EV_PEER_SHARED = 3'd2;
   localparam logic [2:0] EV_ACK_PART    = 3'd3;
   localparam logic [2:0] EV_ACK_DONE    = 3'd4;
   localparam logic [2:0] EV_WB_DONE     = 3'd5;
   localparam logic [2:0] EV_IGNORED     = 3'd6;

   // transient states; read-wait family occupies codes 0..3
   localparam int STATE_W = 4;
   localparam logic [3:0] ST_RD_WAIT    = 4'd0;
   localparam logic [3:0] ST_RD_INV     = 4'd1;
   localparam logic [3:0] ST_PF_RD      = 4'd2;
   localparam logic [3:0] ST_PF_RD_INV  = 4'd3;
   localparam logic [3:0] ST_WR_WAIT    = 4'd4;
   localparam logic [3:0] ST_UPG_WAIT   = 4'd5;
   localparam logic [3:0] ST_WB_WAIT    = 4'd6;
   localparam logic [3:0] ST_PF_WR      = 4'd7;
   localparam logic [3:0] ST_PF_UPG     = 4'd8;

   function automatic logic is_read_wait(input logic [STATE_W-1:0] s);
      return (s == ST_RD_WAIT) || (s == ST_RD_INV) ||
             (s == ST_PF_RD) || (s == ST_PF_RD_INV);
   endfunction
endpackage

// File: rtl/ptrk_entry.sv
module ptrk_entry #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64,
   parameter int CNT_W   = 6,
   parameter int STATE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ADDR_W-1:0]        ld_addr,
   input  logic [STATE_W-1:0]       ld_state,
   input  logic [DATA_W-1:0]        ld_data,
   input  logic                     ld_dirty,
   input  logic                     upd,
   input  logic signed [CNT_W-1:0]  upd_cnt,
   input  logic                     clr,
   output logic                     valid,
   output logic [ADDR_W-1:0]        addr,
   output logic [STATE_W-1:0]       state,
   output logic [DATA_W-1:0]        data,
   output logic                     dirty,
   output logic signed [CNT_W-1:0]  cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         state <= '0;
         data  <= '0;
         dirty <= 1'b0;
         cnt   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         addr  <= ld_addr;
         state <= ld_state;
         data  <= ld_data;
         dirty <= ld_dirty;
         cnt   <= '0;
      end else if (clr) begin
         valid <= 1'b0;
         cnt   <= '0;
      end else if (upd) begin
         cnt   <= upd_cnt;
      end
   end
endmodule

// File: rtl/ptrk_classify.sv
module ptrk_classify
   import ptrk_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic                     hit,
   input  logic [STATE_W-1:0]       state,
   input  logic signed [CNT_W-1:0]  cnt,
   input  logic [1:0]               kind,
   input  logic                     from_peer,
   input  logic signed [CNT_W-1:0]  ack_cnt,
   output logic [2:0]               evt,
   output logic                     retire,
   output logic                     upd,
   output logic signed [CNT_W-1:0]  left
);
   logic signed [CNT_W-1:0] diff;

   always_comb begin
      diff   = cnt - ack_cnt;
      evt    = EV_IGNORED;
      retire = 1'b0;
      upd    = 1'b0;
      left   = '0;
      if (hit) begin
         case (kind)
            RSP_DATA: begin
               if (from_peer && is_read_wait(state)) begin
                  evt    = EV_PEER_SHARED;
                  retire = 1'b1;
               end else if (diff == '0) begin
                  evt    = EV_DATA_DONE;
                  retire = 1'b1;
               end else begin
                  evt  = EV_DATA_PART;
                  upd  = 1'b1;
                  left = diff;
               end
            end
            RSP_ACK: begin
               if (diff == '0) begin
                  evt    = EV_ACK_DONE;
                  retire = 1'b1;
               end else begin
                  evt  = EV_ACK_PART;
                  upd  = 1'b1;
                  left = diff;
               end
            end
            RSP_WBACK: begin
               evt    = EV_WB_DONE;
               retire = 1'b1;
            end
            default: begin
               evt = EV_IGNORED;
            end
         endcase
      end
   end
endmodule

// File: rtl/ptrk_first_free.sv
module ptrk_first_free #(
   parameter int N = 4
) (
   input  logic [N-1:0] busy,
   output logic [N-1:0] grant,
   output logic         any_free
);
   always_comb begin
      grant = '0;
      for (int i = 0; i < N; i++) begin
         if (!busy[i] && (grant == '0)) grant[i] = 1'b1;
      end
      any_free = (grant != '0);
   end
endmodule

// File: rtl/pend_ack_tracker.sv
module pend_ack_tracker
   import ptrk_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int ENTRIES   = 4,
   parameter int CNT_W     = 6,
   parameter bit REG_EVENT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_valid,
   input  logic [ADDR_W-1:0]        alloc_addr,
   input  logic [3:0]               alloc_state,
   input  logic [DATA_W-1:0]        alloc_data,
   input  logic                     alloc_dirty,
   output logic                     alloc_full,
   input  logic                     resp_valid,
   input  logic [ADDR_W-1:0]        resp_addr,
   input  logic [1:0]               resp_type,
   input  logic                     resp_from_peer,
   input  logic signed [CNT_W-1:0]  resp_ack_cnt,
   output logic                     evt_valid,
   output logic [2:0]               evt_code,
   output logic signed [CNT_W-1:0]  evt_left,
   output logic [DATA_W-1:0]        evt_data,
   output logic                     evt_dirty
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pend_ack_tracker: ENTRIES must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("pend_ack_tracker: CNT_W must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pend_ack_tracker: ADDR_W and DATA_W must be positive");
   end

   logic [ENTRIES-1:0]      ent_valid;
   logic [ADDR_W-1:0]       ent_addr  [ENTRIES];
   logic [STATE_W-1:0]      ent_state [ENTRIES];
   logic [DATA_W-1:0]       ent_data  [ENTRIES];
   logic [ENTRIES-1:0]      ent_dirty;
   logic signed [CNT_W-1:0] ent_cnt   [ENTRIES];

   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] sel_oh;
   logic [ENTRIES-1:0] grant;
   logic               any_free;
   logic               alloc_take;

   logic                    hit;
   logic [IDX_W-1:0]        sel_idx;
   logic [STATE_W-1:0]      sel_state;
   logic signed [CNT_W-1:0] sel_cnt;
   logic [DATA_W-1:0]       sel_data;
   logic                    sel_dirty;

   logic [2:0]              cls_evt;
   logic                    cls_retire;
   logic                    cls_upd;
   logic signed [CNT_W-1:0] cls_left;

   // allocation slot
   ptrk_first_free #(.N(ENTRIES)) u_free (
      .busy     (ent_valid),
      .grant    (grant),
      .any_free (any_free)
   );

   assign alloc_full = ~any_free;
   assign alloc_take = alloc_valid & any_free;

   // address lookup
   for (genvar i = 0; i < ENTRIES; i++) begin : g_match
      assign match[i] = ent_valid[i] && (ent_addr[i] == resp_addr);
   end

   always_comb begin
      hit     = 1'b0;
      sel_idx = '0;
      sel_oh  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i] && !hit) begin
            hit       = 1'b1;
            sel_idx   = IDX_W'(i);
            sel_oh[i] = 1'b1;
         end
      end
   end

   assign sel_state = ent_state[sel_idx];
   assign sel_cnt   = ent_cnt[sel_idx];
   assign sel_data  = ent_data[sel_idx];
   assign sel_dirty = ent_dirty[sel_idx];

   ptrk_classify #(.CNT_W(CNT_W)) u_cls (
      .hit       (hit),
      .state     (sel_state),
      .cnt       (sel_cnt),
      .kind      (resp_type),
      .from_peer (resp_from_peer),
      .ack_cnt   (resp_ack_cnt),
      .evt       (cls_evt),
      .retire    (cls_retire),
      .upd       (cls_upd),
      .left      (cls_left)
   );

   // entry storage
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      ptrk_entry #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .CNT_W  (CNT_W),
         .STATE_W(STATE_W)
      ) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (alloc_take & grant[i]),
         .ld_addr  (alloc_addr),
         .ld_state (alloc_state),
         .ld_data  (alloc_data),
         .ld_dirty (alloc_dirty),
         .upd      (resp_valid & sel_oh[i] & cls_upd),
         .upd_cnt  (cls_left),
         .clr      (resp_valid & sel_oh[i] & cls_retire),
         .valid    (ent_valid[i]),
         .addr     (ent_addr[i]),
         .state    (ent_state[i]),
         .data     (ent_data[i]),
         .dirty    (ent_dirty[i]),
         .cnt      (ent_cnt[i])
      );
   end

   // event output stage: registered or pass-through
   if (REG_EVENT) begin : g_evt_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= EV_IGNORED;
            evt_left  <= '0;
            evt_data  <= '0;
            evt_dirty <= 1'b0;
         end else begin
            evt_valid <= resp_valid;
            evt_code  <= cls_evt;
            evt_left  <= cls_left;
            evt_data  <= hit ? sel_data : '0;
            evt_dirty <= hit & sel_dirty;
         end
      end
   end else begin : g_evt_comb
      assign evt_valid = resp_valid;
      assign evt_code  = cls_evt;
      assign evt_left  = cls_left;
      assign evt_data  = hit ? sel_data : '0;
      assign evt_dirty = hit & sel_dirty;
   end
endmodule

// File: rtl/ptrk_chk.sv
module ptrk_chk
   import ptrk_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter bit REG_EVENT = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     alloc_valid,
   input logic                     alloc_full,
   input logic                     resp_valid,
   input logic [1:0]               resp_type,
   input logic                     evt_valid,
   input logic [2:0]               evt_code,
   input logic signed [CNT_W-1:0]  evt_left
);
   // R8
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_full && !resp_valid |=> alloc_full);

   // R8
   full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alloc_full) |-> $past(alloc_valid));

   // R9
   retire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && (evt_code == EV_DATA_DONE || evt_code == EV_PEER_SHARED ||
                    evt_code == EV_ACK_DONE || evt_code == EV_WB_DONE)
      |-> evt_left == '0);

   if (REG_EVENT) begin : g_reg
      // R9
      evt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         resp_valid |=> evt_valid);

      // R9
      evt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !resp_valid |=> !evt_valid);

      // R7
      rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         resp_valid && resp_type == 2'd3 |=> evt_code == EV_IGNORED && evt_left == '0);
   end else begin : g_comb
      // R9
      evt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         resp_valid |-> evt_valid);

      // R7
      rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         resp_valid && resp_type == 2'd3 |-> evt_code == EV_IGNORED && evt_left == '0);
   end
endmodule

bind pend_ack_tracker ptrk_chk #(.CNT_W(CNT_W), .REG_EVENT(REG_EVENT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_valid (alloc_valid),
   .alloc_full  (alloc_full),
   .resp_valid  (resp_valid),
   .resp_type   (resp_type),
   .evt_valid   (evt_valid),
   .evt_code    (evt_code),
   .evt_left    (evt_left)
);

// File: tb/tb_pend_ack_tracker.sv
`timescale 1ns/1ps
module tb_pend_ack_tracker;
   localparam int AW = 32;
   localparam int DW = 64;
   localparam int NE = 4;
   localparam int CW = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 alloc_valid = 1'b0;
   logic [AW-1:0]        alloc_addr = '0;
   logic [3:0]           alloc_state = '0;
   logic [DW-1:0]        alloc_data = '0;
   logic                 alloc_dirty = 1'b0;
   logic                 alloc_full;
   logic                 resp_valid = 1'b0;
   logic [AW-1:0]        resp_addr = '0;
   logic [1:0]           resp_type = '0;
   logic                 resp_from_peer = 1'b0;
   logic signed [CW-1:0] resp_ack_cnt = '0;
   logic                 evt_valid;
   logic [2:0]           evt_code;
   logic signed [CW-1:0] evt_left;
   logic [DW-1:0]        evt_data;
   logic                 evt_dirty;

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;

   // expected table
   logic                 m_v  [NE];
   logic [AW-1:0]        m_a  [NE];
   logic [3:0]           m_s  [NE];
   logic [DW-1:0]        m_d  [NE];
   logic                 m_dy [NE];
   logic signed [CW-1:0] m_p  [NE];

   pend_ack_tracker #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE), .CNT_W(CW)) dut (.*);

   always #10 clk = ~clk;  // 50 MHz

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
         end
      end
   end

   function automatic string tag_of(input logic [2:0] c);
      case (c)
         3'd0: return "R3";
         3'd1: return "R2";
         3'd2: return "R5";
         3'd3, 3'd4: return "R4";
         3'd5: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic model_full();
      for (int i = 0; i < NE; i++) if (!m_v[i]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int model_find(input logic [AW-1:0] a);
      for (int i = 0; i < NE; i++) if (m_v[i] && m_a[i] == a) return i;
      return -1;
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic do_alloc(input logic [AW-1:0] a, input logic [3:0] s,
                           input logic [DW-1:0] d, input logic dy);
      logic full_exp = model_full();
      check("R8", "alloc_full", longint'(alloc_full), longint'(full_exp));
      alloc_valid = 1'b1; alloc_addr = a; alloc_state = s;
      alloc_data = d; alloc_dirty = dy;
      if (!full_exp) begin
         for (int i = 0; i < NE; i++) begin
            if (!m_v[i]) begin
               m_v[i] = 1'b1; m_a[i] = a; m_s[i] = s;
               m_d[i] = d; m_dy[i] = dy; m_p[i] = '0;
               break;
            end
         end
      end
      @(negedge clk);
      alloc_valid = 1'b0;
   endtask

   task automatic do_resp(input logic [AW-1:0] a, input logic [1:0] k,
                          input logic peer, input logic signed [CW-1:0] c);
      int idx = model_find(a);
      logic [2:0] ec = 3'd6;
      logic signed [CW-1:0] el = '0;
      logic signed [CW-1:0] df;
      logic [DW-1:0] ed = '0;
      logic edy = 1'b0;
      if (idx >= 0) begin
         ed = m_d[idx]; edy = m_dy[idx];
         df = m_p[idx] - c;
         if (k == 2'd0) begin
            if (peer && m_s[idx] < 4'd4) begin ec = 3'd2; m_v[idx] = 1'b0; end
            else if (df == 0) begin ec = 3'd1; m_v[idx] = 1'b0; end
            else begin ec = 3'd0; el = df; m_p[idx] = df; end
         end else if (k == 2'd1) begin
            if (df == 0) begin ec = 3'd4; m_v[idx] = 1'b0; end
            else begin ec = 3'd3; el = df; m_p[idx] = df; end
         end else if (k == 2'd2) begin
            ec = 3'd5; m_v[idx] = 1'b0;
         end
      end
      resp_valid = 1'b1; resp_addr = a; resp_type = k;
      resp_from_peer = peer; resp_ack_cnt = c;
      @(negedge clk);
      check("R9", "evt_valid", longint'(evt_valid), 1);
      check(tag_of(ec), "evt_code", longint'(evt_code), longint'(ec));
      check(tag_of(ec), "evt_left", longint'(evt_left), longint'(el));
      if (idx >= 0) begin
         check("R1", "evt_data", longint'(evt_data), longint'(ed));
         check("R1", "evt_dirty", longint'(evt_dirty), longint'(edy));
      end
      resp_valid = 1'b0;
   endtask

   task automatic do_idle();
      @(negedge clk);
      check("R9", "evt_valid idle", longint'(evt_valid), 0);
   endtask

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_v[i] = 1'b0; m_a[i] = '0; m_s[i] = '0; m_d[i] = '0; m_dy[i] = 1'b0; m_p[i] = '0;
      end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10", "alloc_full after reset", longint'(alloc_full), 0);
      check("R10", "evt_valid after reset", longint'(evt_valid), 0);
      do_resp(32'h40, 2'd1, 1'b0, 6'sd1);              // R7 empty table

      // R3 then R4: data first, two acks
      do_alloc(32'h100, 4'd4, 64'hDEAD_BEEF_0123_4567, 1'b1);
      do_resp(32'h100, 2'd0, 1'b0, -6'sd2);            // R3 left 2, R1 snapshot
      do_resp(32'h100, 2'd1, 1'b0, 6'sd1);             // R4 partial, left 1
      do_resp(32'h100, 2'd1, 1'b0, 6'sd1);             // R4 last ack
      do_resp(32'h100, 2'd1, 1'b0, 6'sd1);             // R7 freed
      // R4 negative count, then R2
      do_alloc(32'h140, 4'd5, 64'h1111_2222_3333_4444, 1'b0);
      do_resp(32'h140, 2'd1, 1'b0, 6'sd1);             // R4 left -1
      do_resp(32'h140, 2'd0, 1'b0, -6'sd1);            // R2 complete
      // R5 peer data in read-wait state, and not in write-wait state
      do_alloc(32'h180, 4'd0, 64'hAAAA_0000_5555_FFFF, 1'b0);
      do_resp(32'h180, 2'd0, 1'b1, -6'sd3);            // R5
      do_alloc(32'h1C0, 4'd4, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1);
      do_resp(32'h1C0, 2'd0, 1'b1, -6'sd2);            // R3 not peer-shared
      do_resp(32'h1C0, 2'd1, 1'b0, 6'sd2);             // R4 last
      // R6 writeback ack
      do_alloc(32'h200, 4'd6, 64'hC0FF_EE00_C0FF_EE00, 1'b1);
      do_resp(32'h200, 2'd3, 1'b0, 6'sd0);             // R7 reserved type
      do_resp(32'h200, 2'd2, 1'b0, 6'sd0);             // R6
      do_idle();                                       // R9
      // R8 full table
      for (int i = 0; i < NE; i++)
         do_alloc(32'h500 + 32'(i) * 32'h40, 4'd6, 64'(i) + 64'h77, 1'b0);
      do_alloc(32'h900, 4'd4, 64'h99, 1'b1);           // R8 ignored while full
      check("R8", "alloc_full held", longint'(alloc_full), 1);
      do_resp(32'h900, 2'd0, 1'b0, 6'sd0);             // R7/R8 no entry created
      for (int i = 0; i < NE; i++)
         do_resp(32'h500 + 32'(i) * 32'h40, 2'd2, 1'b0, 6'sd0);
      check("R8", "alloc_full cleared", longint'(alloc_full), 0);

      // random phase
      for (int n = 0; n < 600; n++) begin
         int op = int'($urandom % 10);
         logic [AW-1:0] a = 32'h1000 + 32'($urandom % 6) * 32'h40;
         if (op < 3) begin
            if (model_find(a) < 0)
               do_alloc(a, 4'($urandom % 9), {$urandom, $urandom}, 1'($urandom));
            else
               do_idle();
         end else if (op < 9) begin
            logic [1:0] k = ($urandom % 8 == 0) ? 2'(3 - ($urandom % 2)) : 2'($urandom % 2);
            logic peer = ($urandom % 4 == 0);
            logic signed [CW-1:0] c;
            if (k == 2'd0) c = -CW'($urandom % 3);
            else if ($urandom % 4 == 0) c = CW'(int'($urandom % 4) - 1);
            else c = 6'sd1;
            do_resp(a, k, peer, c);
         end else begin
            do_idle();
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule